// File: doc/BRIEF.md
# Predicate Remap Table

This unit turns a block of predicate-table entries, each of which names a target register, into two register-indexed lookup arrays: one for integer registers and one for floating-point registers. Each array has one slot per register. A slot records whether predication is active for that register, which integer register supplies the predicate mask, and the zeroing, inversion and fail-first options. The execution pipeline later reads a slot by bank and register number and gets the settings back in the same cycle.

Entries arrive one per cycle while `entryValid` is high. They come either in a full 16-bit form or in a compact 8-bit form. In the compact form the predicate register is implicit: it is x9 plus the entry's position in the block. A pulse on `clear` starts a new block. It disables every slot and sets the position counter back to zero.

An entry that combines predicate register x0 with both zeroing and inversion is illegal. It writes nothing and raises a one-cycle trap flag.

Top module: `predRemap`

## Requirements
- R1: After reset, and after any cycle with `clear` high, every slot of both banks reads back with enabled=0, all other fields 0 and `rdAllOnes`=1.
- R2: A 16-bit entry (`entryFmt8`=0) is decoded as follows:
  - bits 15..11 are the predicate register;
  - bit 10 is zeroing;
  - bit 9 is invert;
  - bit 8 is the bank (0 = integer, 1 = floating-point);
  - bits 7..1 are the target slot;
  - bit 0 is fail-first.

  The entry's slot reads back enabled=1 with these fields from the cycle after it is accepted.
- R3: A 16-bit entry whose predicate register is 0 and whose zeroing and invert bits are both 1 changes no slot. It drives `illegalTrap` high for exactly the one cycle after it is accepted, and the flag is low otherwise.
- R4: A compact entry (`entryFmt8`=1) is decoded as follows:
  - bit 7 is zeroing;
  - bit 6 is invert;
  - bit 5 is the bank;
  - bits 4..0 are the target slot;
  - bits 15..8 are ignored.

  Its predicate register is 9 plus its position in the block, and its fail-first bit is stored as 0.
- R5: Accepted entries are numbered from position 0 upward since the last clear or reset. A compact entry at position 4 or higher changes nothing but still uses up its position. Once MAX_ENTRIES (16) entries have been accepted, further entries change nothing and raise no trap until the next clear.
- R6: A later entry that targets the same bank and slot replaces every field written by the earlier one.
- R7: A 16-bit entry whose target index is NUM_SLOTS (32) or above changes no slot in either bank.
- R8: `rdAllOnes` is 1 when the addressed slot is not enabled, or when its predicate register is 0 with invert set. Otherwise it is 0.
- R9: When `clear` and `entryValid` are high in the same cycle, the clear takes effect and the entry is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| clear | input | 1 | Disable all slots and restart the position count |
| entryValid | input | 1 | An entry is presented this cycle |
| entryFmt8 | input | 1 | 1 = compact 8-bit entry in bits 7..0, 0 = 16-bit entry |
| entryData | input | 16 | Entry contents |
| illegalTrap | output | 1 | One-cycle flag for a reserved entry |
| rdBank | input | 1 | Lookup bank: 0 integer, 1 floating-point |
| rdReg | input | 5 | Lookup register number |
| rdEnabled | output | 1 | Addressed slot is active |
| rdZero | output | 1 | Zeroing option of the slot |
| rdInv | output | 1 | Invert option of the slot |
| rdFfirst | output | 1 | Fail-first option of the slot |
| rdPredReg | output | 5 | Predicate register of the slot |
| rdAllOnes | output | 1 | Effective predicate mask is all ones |

## Verification
Random 16-bit and compact entries are mixed with frequent clears and checked against a bench model of both banks. Each random entry is checked at its own slot, which tests the field decoding, and at a random slot, which catches writes that land in the wrong slot.

Directed patterns cover the following cases:
- the reserved combination next to its legal neighbours (x0 with only invert, and x0 with only zeroing), which separates the trap from the all-ones mask case;
- an out-of-range target index that aliases onto slot 8, which would expose truncation of the index;
- five compact entries, which show the implicit register step and the position limit;
- seventeen entries, which exercise the block-length cutoff;
- a clear in the same cycle as an entry, which settles which one takes priority.

// File: rtl/predRemapPkg.sv
`timescale 1ns/1ps
package predRemapPkg;
  localparam int REG_W = 5;   // predicate register number width
  localparam int TGT_W = 7;   // target index field width in a 16-bit entry

  typedef struct packed {
    logic             enabled;
    logic             zero;
    logic             inv;
    logic             ffirst;
    logic [REG_W-1:0] predReg;
  } slotT;

  typedef struct packed {
    logic             clearAll;
    logic             wrEn;
    logic             wrBank;
    logic [TGT_W-1:0] wrSlot;
    slotT             wrData;
  } strobeT;
endpackage

// File: rtl/predRemapCtrl.sv
`timescale 1ns/1ps
module predRemapCtrl
  import predRemapPkg::*;
#(
  parameter int MAX_ENTRIES  = 16,
  parameter int NUM_SLOTS    = 32,
  parameter int COMPACT_BASE = 9,
  parameter int COMPACT_MAX  = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        clear,
  input  logic        entryValid,
  input  logic        entryFmt8,
  input  logic [15:0] entryData,
  output strobeT      strobe,
  output logic        illegalTrap
);
  localparam int CNT_W = $clog2(MAX_ENTRIES + 1);

  logic [CNT_W-1:0] posCnt;
  logic             haveRoom;
  logic             accept;
  logic             formatOk;
  logic             reserved;
  logic             inRange;
  logic             decBank;
  logic [TGT_W-1:0] decTgt;
  slotT             decSlot;

  assign haveRoom = posCnt < CNT_W'(MAX_ENTRIES);
  assign accept   = entryValid && !clear && haveRoom;

  always_comb begin
    decSlot.enabled = 1'b1;
    if (entryFmt8) begin
      decSlot.zero    = entryData[7];
      decSlot.inv     = entryData[6];
      decBank         = entryData[5];
      decTgt          = {2'b00, entryData[4:0]};
      decSlot.ffirst  = 1'b0;
      decSlot.predReg = REG_W'(COMPACT_BASE) + REG_W'(posCnt);
      formatOk        = posCnt < CNT_W'(COMPACT_MAX);
    end else begin
      decSlot.predReg = entryData[15:11];
      decSlot.zero    = entryData[10];
      decSlot.inv     = entryData[9];
      decBank         = entryData[8];
      decTgt          = entryData[7:1];
      decSlot.ffirst  = entryData[0];
      formatOk        = 1'b1;
    end
  end

  assign reserved = !entryFmt8 && (decSlot.predReg == '0) && decSlot.zero && decSlot.inv;
  assign inRange  = {1'b0, decTgt} < (TGT_W+1)'(NUM_SLOTS);

  always_comb begin
    strobe.clearAll = clear;
    strobe.wrEn     = accept && formatOk && !reserved && inRange;
    strobe.wrBank   = decBank;
    strobe.wrSlot   = decTgt;
    strobe.wrData   = decSlot;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      posCnt      <= '0;
      illegalTrap <= 1'b0;
    end else begin
      illegalTrap <= accept && reserved;
      if (clear)       posCnt <= '0;
      else if (accept) posCnt <= posCnt + 1'b1;
    end
  end
endmodule

// File: rtl/predRemapStore.sv
`timescale 1ns/1ps
module predRemapStore
  import predRemapPkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int NUM_BANKS = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  strobeT                        strobe,
  input  logic [$clog2(NUM_BANKS)-1:0]  rdBank,
  input  logic [$clog2(NUM_SLOTS)-1:0]  rdReg,
  output slotT                          rdSlot,
  output logic                          rdAllOnes
);
  slotT bankRd [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    slotT cells [NUM_SLOTS];
    always_ff @(posedge clk) begin
      for (int s = 0; s < NUM_SLOTS; s++) begin
        if (!rstN || strobe.clearAll)
          cells[s] <= '0;
        else if (strobe.wrEn && (32'(strobe.wrBank) == b) && (32'(strobe.wrSlot) == s))
          cells[s] <= strobe.wrData;
      end
    end
    assign bankRd[b] = cells[rdReg];
  end

  assign rdSlot    = bankRd[rdBank];
  assign rdAllOnes = !rdSlot.enabled || ((rdSlot.predReg == '0) && rdSlot.inv);
endmodule

// File: rtl/predRemap.sv
`timescale 1ns/1ps
module predRemap
  import predRemapPkg::*;
#(
  parameter int MAX_ENTRIES  = 16,
  parameter int NUM_SLOTS    = 32,
  parameter int COMPACT_BASE = 9,
  parameter int COMPACT_MAX  = 4,
  localparam int SLOT_W      = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clear,
  input  logic              entryValid,
  input  logic              entryFmt8,
  input  logic [15:0]       entryData,
  output logic              illegalTrap,
  input  logic              rdBank,
  input  logic [SLOT_W-1:0] rdReg,
  output logic              rdEnabled,
  output logic              rdZero,
  output logic              rdInv,
  output logic              rdFfirst,
  output logic [REG_W-1:0]  rdPredReg,
  output logic              rdAllOnes
);
  strobeT strobe;
  slotT   rdSlot;

  predRemapCtrl #(
    .MAX_ENTRIES(MAX_ENTRIES), .NUM_SLOTS(NUM_SLOTS),
    .COMPACT_BASE(COMPACT_BASE), .COMPACT_MAX(COMPACT_MAX)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .clear(clear), .entryValid(entryValid),
    .entryFmt8(entryFmt8), .entryData(entryData),
    .strobe(strobe), .illegalTrap(illegalTrap)
  );

  predRemapStore #(.NUM_SLOTS(NUM_SLOTS), .NUM_BANKS(2)) u_store (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdBank(rdBank), .rdReg(rdReg),
    .rdSlot(rdSlot), .rdAllOnes(rdAllOnes)
  );

  assign rdEnabled = rdSlot.enabled;
  assign rdZero    = rdSlot.zero;
  assign rdInv     = rdSlot.inv;
  assign rdFfirst  = rdSlot.ffirst;
  assign rdPredReg = rdSlot.predReg;
endmodule

// File: rtl/predRemapChk.sv
`timescale 1ns/1ps
module predRemapChk
  import predRemapPkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        clear,
  input logic        entryValid,
  input logic        entryFmt8,
  input logic [15:0] entryData,
  input logic        illegalTrap,
  input logic        rdEnabled,
  input logic        rdAllOnes,
  input strobeT      strobe
);
  // R1 / R9: a clear leaves every slot disabled in the following cycle
  a_r1_clear_disables: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> !rdEnabled);

  // R3: the trap is only raised after a reserved 16-bit entry
  a_r3_trap_cause: assert property (@(posedge clk) disable iff (!rstN)
    illegalTrap |-> $past(entryValid && !entryFmt8 && (entryData[15:11] == 5'd0)
                          && entryData[10] && entryData[9]));

  // R3: the reserved combination never reaches storage
  a_r3_no_reserved_write: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |-> !((strobe.wrData.predReg == '0) && strobe.wrData.zero && strobe.wrData.inv));

  // R4: compact writes carry an implicit register 9..12 and no fail-first
  a_r4_compact_write: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && entryFmt8) |-> (!strobe.wrData.ffirst
      && strobe.wrData.predReg >= 5'd9 && strobe.wrData.predReg <= 5'd12));

  // R2: every write marks its slot enabled
  a_r2_write_enabled: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |-> strobe.wrData.enabled);

  // R8: a disabled slot always reports an all-ones mask
  a_r8_disabled_mask: assert property (@(posedge clk) disable iff (!rstN)
    !rdEnabled |-> rdAllOnes);
endmodule

bind predRemap predRemapChk u_chk (
  .clk(clk), .rstN(rstN), .clear(clear), .entryValid(entryValid),
  .entryFmt8(entryFmt8), .entryData(entryData), .illegalTrap(illegalTrap),
  .rdEnabled(rdEnabled), .rdAllOnes(rdAllOnes), .strobe(strobe)
);

// File: tb/test_predRemap.sv
`timescale 1ns/1ps
module test_predRemap;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        clear = 1'b0;
  logic        entryValid = 1'b0;
  logic        entryFmt8 = 1'b0;
  logic [15:0] entryData = '0;
  logic        illegalTrap;
  logic        rdBank = 1'b0;
  logic [4:0]  rdReg = '0;
  logic        rdEnabled, rdZero, rdInv, rdFfirst, rdAllOnes;
  logic [4:0]  rdPredReg;

  int nChecks = 0;
  int nFail = 0;

  bit       mEn [2][32];
  bit       mZ  [2][32];
  bit       mI  [2][32];
  bit       mF  [2][32];
  bit [4:0] mP  [2][32];
  int       mCnt = 0;
  bit       mTrap = 0;

  always #2 clk = ~clk;

  predRemap i_predRemap (
    .clk(clk), .rstN(rstN), .clear(clear), .entryValid(entryValid),
    .entryFmt8(entryFmt8), .entryData(entryData), .illegalTrap(illegalTrap),
    .rdBank(rdBank), .rdReg(rdReg), .rdEnabled(rdEnabled), .rdZero(rdZero),
    .rdInv(rdInv), .rdFfirst(rdFfirst), .rdPredReg(rdPredReg), .rdAllOnes(rdAllOnes)
  );

  function automatic void modelClear();
    for (int b = 0; b < 2; b++)
      for (int s = 0; s < 32; s++) begin
        mEn[b][s] = 0; mZ[b][s] = 0; mI[b][s] = 0; mF[b][s] = 0; mP[b][s] = 0;
      end
    mCnt = 0;
  endfunction

  function automatic void modelStep(bit clr, bit v, bit f8, bit [15:0] d);
    int pos, b, t;
    bit z, i, f;
    bit [4:0] p;
    mTrap = 0;
    if (clr) begin modelClear(); return; end
    if (!v || mCnt >= 16) return;
    pos = mCnt;
    mCnt++;
    if (f8) begin
      if (pos >= 4) return;
      z = d[7]; i = d[6]; b = int'(d[5]); t = int'(d[4:0]); f = 0; p = 5'(9 + pos);
    end else begin
      p = d[15:11]; z = d[10]; i = d[9]; b = int'(d[8]); t = int'(d[7:1]); f = d[0];
      if (p == 0 && z && i) begin mTrap = 1; return; end
      if (t >= 32) return;
    end
    mEn[b][t] = 1; mZ[b][t] = z; mI[b][t] = i; mF[b][t] = f; mP[b][t] = p;
  endfunction

  task automatic check(bit ok, string req, logic [15:0] act, logic [15:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // packed readback: {enabled, zero, inv, ffirst, predReg, allOnes}
  task automatic checkSlot(int b, int s, string req);
    logic [9:0] act, exp;
    @(negedge clk);
    rdBank = b[0];
    rdReg  = 5'(s);
    #1;
    exp = {mEn[b][s], mZ[b][s], mI[b][s], mF[b][s], mP[b][s],
           !mEn[b][s] || (mP[b][s] == 0 && mI[b][s])};
    act = {rdEnabled, rdZero, rdInv, rdFfirst, rdPredReg, rdAllOnes};
    check(act === exp, req, 16'(act), 16'(exp));
  endtask

  task automatic step(bit clr, bit v, bit f8, bit [15:0] d);
    @(negedge clk);
    clear = clr; entryValid = v; entryFmt8 = f8; entryData = d;
    modelStep(clr, v, f8, d);
    @(negedge clk);
    clear = 0; entryValid = 0;
    check(illegalTrap === mTrap, "R3 trap", 16'(illegalTrap), 16'(mTrap));
    if (mTrap) begin
      @(negedge clk);
      check(illegalTrap === 1'b0, "R3 trap one cycle", 16'(illegalTrap), 16'h0);
    end
  endtask

  function automatic bit [15:0] full(int p, bit z, bit i, bit b, int t, bit f);
    return {5'(p), z, i, b, 7'(t), f};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    modelClear();
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    // R1: reset state of every slot
    check(illegalTrap === 1'b0, "R1 trap after reset", 16'(illegalTrap), 16'h0);
    for (int b = 0; b < 2; b++)
      for (int s = 0; s < 32; s++) checkSlot(b, s, "R1 reset slot");

    // R2: full entries in both banks
    step(0, 1, 0, full(7, 1, 0, 0, 3, 1));
    checkSlot(0, 3, "R2 int slot");
    checkSlot(1, 3, "R2 other bank untouched");
    step(0, 1, 0, full(20, 0, 1, 1, 31, 0));
    checkSlot(1, 31, "R2 fp slot");

    // R6: overwrite same slot
    step(0, 1, 0, full(4, 0, 0, 0, 3, 0));
    checkSlot(0, 3, "R6 overwrite");

    // R3: reserved entry, then its legal neighbours
    step(0, 1, 0, full(0, 1, 1, 0, 5, 1));
    checkSlot(0, 5, "R3 no write");
    step(0, 1, 0, full(0, 0, 1, 0, 6, 1));
    checkSlot(0, 6, "R8 x0 inverted all ones");
    step(0, 1, 0, full(0, 1, 0, 1, 6, 0));
    checkSlot(1, 6, "R8 x0 non-inverted");

    // R7: out-of-range target (40 would alias to 8)
    step(0, 1, 0, full(2, 0, 0, 0, 40, 0));
    checkSlot(0, 8, "R7 out of range int");
    step(0, 1, 0, full(2, 0, 0, 1, 40, 0));
    checkSlot(1, 8, "R7 out of range fp");

    // R1 clear, R4/R5 compact positions
    step(1, 0, 0, 16'h0);
    checkSlot(0, 3, "R1 cleared slot");
    for (int k = 0; k < 5; k++) step(0, 1, 1, {8'hFF, 1'b1, 1'b0, k[0], 5'(k + 10)});
    for (int k = 0; k < 5; k++) checkSlot(k % 2, k + 10, "R4 R5 compact position");

    // R5: more than MAX_ENTRIES entries
    step(1, 0, 0, 16'h0);
    for (int k = 0; k < 17; k++) step(0, 1, 0, full(k + 1, 0, 0, 0, k, 1));
    for (int k = 15; k < 17; k++) checkSlot(0, k, "R5 block length limit");
    step(0, 1, 0, full(0, 1, 1, 0, 1, 0));
    checkSlot(0, 1, "R5 full block ignores reserved");

    // R9: clear with entry in same cycle
    step(1, 1, 0, full(3, 0, 0, 0, 2, 0));
    checkSlot(0, 2, "R9 clear wins");
    step(0, 1, 0, full(3, 0, 0, 0, 2, 0));
    checkSlot(0, 2, "R9 count restarted");

    // random mix (R2 R3 R4 R5 R6 R7 R8)
    for (int n = 0; n < 400; n++) begin
      bit clr, f8;
      bit [15:0] d;
      int b, t;
      clr = ($urandom % 10) == 0;
      f8  = ($urandom % 3) == 0;
      d   = 16'($urandom);
      if (($urandom % 8) == 0) d[15:9] = 7'b0000011;
      if (($urandom % 8) != 0) d[7] = 1'b0;
      step(clr, 1, f8, d);
      b = f8 ? int'(d[5]) : int'(d[8]);
      t = f8 ? int'(d[4:0]) : int'(d[6:1]);
      checkSlot(b, t % 32, "R2 R4 random own slot");
      checkSlot($urandom % 2, $urandom % 32, "R6 R8 random other slot");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule